// File: doc/BRIEF.md
# Dual-reference clock selector

This block decides which of two reference clocks feeds a single PLL channel. It watches both references with activity monitors that run on a free-running system clock. It raises a loss alarm for each reference that goes quiet, and it turns a 2-bit mode code into a registered select output.

Two modes are manual: one follows an external pin and the other follows a register bit. The other two modes fail over automatically, one with reversion and one without. In the automatic modes the register bit names the primary reference instead of forcing the choice.

The block also reports holdover when both references are lost. It gives a one-cycle event pulse whenever the selection changes, so that downstream logic can count failovers. The loss timeout and the qualification count arrive as plain register inputs.

Top module: `refclk_selector`

## Requirements
- R1: With mode code 2'b00 the select output follows `pin_sel` one system-clock cycle later, and `reg_sel` has no effect on it.
- R2: With mode code 2'b11 the select output follows `reg_sel` one system-clock cycle later (0 picks reference 0, 1 picks reference 1), and `pin_sel` has no effect on it.
- R3: `alarm[i]` is high from reset, and it goes high again once reference i shows no rising edge for `loss_limit` system-clock cycles.
- R4: A lost reference clears its alarm only after `qual_limit` consecutive rising edges, with no gap of `loss_limit` cycles between them.
- R5: On entry to an automatic mode (2'b01 or 2'b10), the next cycle selects the primary named by `reg_sel` if that reference is valid, and the other reference if it is not.
- R6: In mode 2'b01 the block moves to the other reference when the active one is lost, and it stays there after the primary recovers.
- R7: In mode 2'b10 the block moves back to the primary as soon as the primary is valid again.
- R8: In the automatic modes the block never moves to a reference whose alarm is set. When both alarms are set it keeps its selection and raises `holdover` on the next cycle.
- R9: `switch_evt` pulses high for exactly the one cycle in which `sel` takes a new value, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk0 | input | 1 | Reference clock 0 (asynchronous) |
| ref_clk1 | input | 1 | Reference clock 1 (asynchronous) |
| mode | input | 2 | 00 pin, 01 auto non-revertive, 10 auto revertive, 11 register |
| reg_sel | input | 1 | Register select bit; primary designation in auto modes |
| pin_sel | input | 1 | External select pin |
| loss_limit | input | CNT_W | Edge-free cycles before a reference is declared lost |
| qual_limit | input | CNT_W | Consecutive edges needed to requalify a reference |
| sel | output | 1 | Selected reference (0 or 1) |
| alarm | output | 2 | Per-reference loss alarm |
| holdover | output | 1 | Both references lost in an automatic mode |
| switch_evt | output | 1 | One-cycle pulse on each selection change |

## Verification
The assertions check four things on every cycle. In both manual modes the select follows its source one cycle later. `switch_evt` matches exactly the cycles in which `sel` changes. An automatic switch outside a mode change never lands on an alarmed reference. `holdover` follows from both alarms being set in an automatic mode.

Other behaviour needs a sequence of events, so only the directed scenarios can show it. These cover qualification after a given number of edges, the loss timeout, non-revertive stickiness after the primary recovers, reversion to the primary, and the choice of starting reference on entry into an automatic mode.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_PIN      = 2'b00,
        MODE_AUTO_NR  = 2'b01,
        MODE_AUTO_REV = 2'b10,
        MODE_REG      = 2'b11
    } sel_mode_e;

    typedef struct packed {
        logic       sel;
        logic       holdover;
        logic       switch_evt;
    } sel_state_t;

    function automatic logic is_auto(input logic [1:0] m);
        return (m == MODE_AUTO_NR) || (m == MODE_AUTO_REV);
    endfunction

endpackage

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic [CNT_W-1:0] loss_limit,
    input  logic [CNT_W-1:0] qual_limit,
    output logic             valid
);
    localparam int SH_W = SYNC_N + 1;
    localparam logic [CNT_W-1:0] GAP_MAX = '1;

    logic [SH_W-1:0]  sync_sh;
    logic             rise;
    logic [CNT_W-1:0] gap_cnt;
    logic [CNT_W-1:0] qual_cnt;
    logic             gone;

    // synchronizer chain plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= {sync_sh[SH_W-2:0], ref_in};
    end

    assign rise = sync_sh[SH_W-2] & ~sync_sh[SH_W-1];

    // cycles since the last detected rising edge, saturating
    always_ff @(posedge clk) begin
        if (rst)                   gap_cnt <= '0;
        else if (rise)             gap_cnt <= '0;
        else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
    end

    assign gone = (gap_cnt >= loss_limit);

    // loss detection and edge-count requalification
    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            qual_cnt <= '0;
        end else if (valid) begin
            if (gone) begin
                valid    <= 1'b0;
                qual_cnt <= '0;
            end
        end else if (gone) begin
            qual_cnt <= '0;
        end else if (rise) begin
            if (qual_cnt + 1'b1 >= qual_limit) begin
                valid    <= 1'b1;
                qual_cnt <= '0;
            end else begin
                qual_cnt <= qual_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
    import refsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       reg_sel,
    input  logic       pin_sel,
    input  logic [1:0] valid,
    output sel_state_t st
);
    logic [1:0] mode_q;
    logic       auto_q;
    logic       entering;
    logic       cur_ok;
    logic       alt_ok;
    logic       prim_ok;
    logic       nxt_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PIN;
            auto_q <= 1'b0;
        end else begin
            mode_q <= mode;
            auto_q <= is_auto(mode);
        end
    end

    assign entering = is_auto(mode) && (!auto_q || (mode != mode_q));
    assign cur_ok   = valid[st.sel];
    assign alt_ok   = valid[~st.sel];
    assign prim_ok  = valid[reg_sel];

    always_comb begin
        nxt_sel = st.sel;
        unique case (sel_mode_e'(mode))
            MODE_PIN: nxt_sel = pin_sel;
            MODE_REG: nxt_sel = reg_sel;
            MODE_AUTO_NR, MODE_AUTO_REV: begin
                if (entering) begin
                    nxt_sel = prim_ok ? reg_sel : ~reg_sel;
                end else if (!cur_ok && alt_ok) begin
                    nxt_sel = ~st.sel;
                end else if ((mode == MODE_AUTO_REV) && (st.sel != reg_sel) && prim_ok) begin
                    nxt_sel = reg_sel;
                end
            end
            default: nxt_sel = st.sel;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.sel        <= nxt_sel;
            st.switch_evt <= (nxt_sel != st.sel);
            st.holdover   <= is_auto(mode) && (valid == 2'b00);
        end
    end

endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
    import refsel_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_clk0,
    input  logic             ref_clk1,
    input  logic [1:0]       mode,
    input  logic             reg_sel,
    input  logic             pin_sel,
    input  logic [CNT_W-1:0] loss_limit,
    input  logic [CNT_W-1:0] qual_limit,
    output logic             sel,
    output logic [1:0]       alarm,
    output logic             holdover,
    output logic             switch_evt
);
    localparam int N_REF = 2;

    logic [N_REF-1:0] ref_vec;
    logic [N_REF-1:0] valid;
    sel_state_t       st;

    assign ref_vec = {ref_clk1, ref_clk0};

    for (genvar i = 0; i < N_REF; i++) begin : g_mon
        ref_activity_mon #(
            .CNT_W  (CNT_W),
            .SYNC_N (SYNC_N)
        ) u_mon (
            .clk        (clk),
            .rst        (rst),
            .ref_in     (ref_vec[i]),
            .loss_limit (loss_limit),
            .qual_limit (qual_limit),
            .valid      (valid[i])
        );
    end

    ref_sel_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .reg_sel (reg_sel),
        .pin_sel (pin_sel),
        .valid   (valid),
        .st      (st)
    );

    assign alarm      = ~valid;
    assign sel        = st.sel;
    assign holdover   = st.holdover;
    assign switch_evt = st.switch_evt;

endmodule

// File: rtl/refclk_selector_chk.sv
module refclk_selector_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       reg_sel,
    input logic       pin_sel,
    input logic       sel,
    input logic [1:0] alarm,
    input logic       holdover,
    input logic       switch_evt
);
    // R1
    pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 2'b00) |-> (sel == $past(pin_sel)));

    // R2
    reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 2'b11) |-> (sel == $past(reg_sel)));

    // R9
    evt_only_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && switch_evt) |-> (sel != $past(sel)));

    // R9
    change_gives_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sel != $past(sel)) |-> switch_evt);

    // R8
    no_switch_to_lost_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && switch_evt
         && ($past(mode) == 2'b01 || $past(mode) == 2'b10)
         && $past(mode) == $past(mode, 2))
        |-> (($past(alarm) & (sel ? 2'b10 : 2'b01)) == 2'b00));

    // R8
    holdover_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode) == 2'b01 || $past(mode) == 2'b10)
         && $past(alarm) == 2'b11) |-> holdover);

endmodule

bind refclk_selector refclk_selector_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .reg_sel    (reg_sel),
    .pin_sel    (pin_sel),
    .sel        (sel),
    .alarm      (alarm),
    .holdover   (holdover),
    .switch_evt (switch_evt)
);

// File: tb/refclk_selector_bench.sv
module refclk_selector_bench;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk0 = 1'b0;
    logic ref_clk1 = 1'b0;
    logic [1:0] mode = 2'b11;
    logic reg_sel = 1'b0;
    logic pin_sel = 1'b0;
    logic [CNT_W-1:0] loss_limit = 16'd20;
    logic [CNT_W-1:0] qual_limit = 16'd4;
    logic sel;
    logic [1:0] alarm;
    logic holdover;
    logic switch_evt;

    logic run0 = 1'b0;
    logic run1 = 1'b0;
    logic [2:0] div0 = '0;
    logic [2:0] div1 = '0;
    int checks = 0;
    int errors = 0;
    int evt_cnt = 0;

    always #4 clk = ~clk;

    refclk_selector #(.CNT_W(CNT_W)) u_refclk_selector (
        .clk(clk), .rst(rst), .ref_clk0(ref_clk0), .ref_clk1(ref_clk1),
        .mode(mode), .reg_sel(reg_sel), .pin_sel(pin_sel),
        .loss_limit(loss_limit), .qual_limit(qual_limit),
        .sel(sel), .alarm(alarm), .holdover(holdover), .switch_evt(switch_evt)
    );

    // reference generators: ref0 rises every 8 cycles, ref1 every 10
    always @(posedge clk) begin
        if (run0) begin
            if (div0 == 3'd3) begin div0 <= '0; ref_clk0 <= ~ref_clk0; end
            else div0 <= div0 + 1'b1;
        end
        if (run1) begin
            if (div1 == 3'd4) begin div1 <= '0; ref_clk1 <= ~ref_clk1; end
            else div1 <= div1 + 1'b1;
        end
    end

    always @(negedge clk) if (!rst && switch_evt) evt_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(4);
        check("R3 reset alarm", alarm, 2'b11);
        check("R9 reset sel", sel, 0);
        check("R9 reset evt", switch_evt, 0);
        check("R8 reset holdover", holdover, 0);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_monitor();
        run0 = 1'b1;
        cyc(20);
        check("R4 not yet qualified", alarm[0], 1);
        cyc(60);
        check("R4 ref0 qualified", alarm[0], 0);
        check("R3 ref1 still lost", alarm[1], 1);
        run1 = 1'b1;
        cyc(80);
        check("R4 ref1 qualified", alarm[1], 0);
    endtask

    task automatic t_reg();
        mode = 2'b11; reg_sel = 1'b0;
        cyc(2);
        reg_sel = 1'b1;
        cyc(1);
        check("R2 reg select next cycle", sel, 1);
        check("R9 evt pulse", switch_evt, 1);
        cyc(1);
        check("R9 evt one cycle", switch_evt, 0);
        pin_sel = 1'b0;
        cyc(3);
        check("R2 pin ignored", sel, 1);
    endtask

    task automatic t_pin();
        pin_sel = 1'b1;
        mode = 2'b00;
        cyc(1);
        reg_sel = 1'b0;
        cyc(3);
        check("R1 reg ignored", sel, 1);
        pin_sel = 1'b0;
        cyc(1);
        check("R1 pin follows", sel, 0);
    endtask

    task automatic t_nonrev();
        reg_sel = 1'b0;
        mode = 2'b01;
        cyc(1);
        check("R5 start on valid primary", sel, 0);
        evt_cnt = 0;
        run0 = 1'b0;
        cyc(60);
        check("R3 ref0 lost", alarm[0], 1);
        check("R6 failover to ref1", sel, 1);
        check("R9 one event per failover", evt_cnt, 1);
        run0 = 1'b1;
        cyc(80);
        check("R4 ref0 back", alarm[0], 0);
        check("R6 stays on backup", sel, 1);
    endtask

    task automatic t_rev();
        mode = 2'b10;
        cyc(1);
        check("R5 entry picks primary", sel, 0);
        run0 = 1'b0;
        cyc(60);
        check("R7 failover", sel, 1);
        run0 = 1'b1;
        cyc(80);
        check("R7 reverts to primary", sel, 0);
    endtask

    task automatic t_hold();
        run0 = 1'b0;
        cyc(60);
        check("R8 on ref1", sel, 1);
        evt_cnt = 0;
        run1 = 1'b0;
        cyc(60);
        check("R8 both lost alarm", alarm, 2'b11);
        check("R8 holdover", holdover, 1);
        check("R8 selection held", sel, 1);
        check("R8 no switch", evt_cnt, 0);
        run1 = 1'b1;
        cyc(80);
        check("R8 holdover clears", holdover, 0);
        mode = 2'b11; reg_sel = 1'b0;
        cyc(2);
        check("R2 manual to lost ref", sel, 0);
        mode = 2'b01;
        cyc(1);
        check("R5 entry with lost primary", sel, 1);
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_monitor();
        t_reg();
        t_pin();
        t_nonrev();
        t_rev();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule